// File: doc/BRIEF.md
# OTP Programming Port Controller

This block is the device-side logic that services a one-time-programmable program store while the chip sits in its programming mode. No address bus reaches the pins. An external programmer selects an operation with a four-bit mode code and walks a hidden word pointer forward by pulsing an update clock. Each step of the pointer takes four update pulses. The pointer advances on the third falling edge of each group of four.

The 16-bit words cross an 8-bit data port one byte at a time. The byte is chosen by the pulse phase inside the group: phases 0 and 1 carry the low byte and phases 2 and 3 carry the high byte. A write can only clear bits, and the store comes out of reset erased to all ones. The update clock, the mode code and the incoming data byte are asynchronous to the system clock. They pass through a two-flop synchronizer, and their edges are detected in the system clock domain.

The port is a set of plain pad-level signals with no valid/ready handshake and no back-pressure. The programmer sets the pace through the update clock, and the block keeps up with any pulse that lasts at least a few system cycles. The pad ring builds the bidirectional pins from `dq_in`, `dq_out` and `dq_oe`.

Top module: `otp_prog_port`

## Requirements
- R1: After reset the pointer and the phase are 0, every word of the store reads 16'hFFFF, and `dq_oe` is low.
- R2: The mode code uses bit 0 for the first mode pin. The codes decode as follows: 4'b0101 is clear, 4'b1110 is write, 4'b1100 is verify, and 4'b1101 or 4'b1111 is inhibit. Every other code behaves exactly as inhibit.
- R3: Outside clear mode, each falling edge of the synchronized update clock advances the phase by one, modulo 4. The pointer increases by one on the falling edge that leaves phase 2, which is the third falling edge of a group.
- R4: While clear mode is selected, the pointer and the phase are both held at 0, and update-clock edges have no effect.
- R5: In verify mode `dq_oe` is high. `dq_out` shows the low byte of the word at the group's pointer in phases 0 and 1, and the high byte of that same word in phases 2 and 3.
- R6: In write mode, a rising update edge in phase 0 or 1 captures the low byte from `dq_in`. On the third falling edge, the word made of the `dq_in` value at that edge (high byte) and the captured low byte is committed to the current pointer.
- R7: A commit ANDs the new word into the stored word, so a bit that is 0 never returns to 1.
- R8: `dq_oe` is low in clear, write, inhibit and undefined modes.
- R9: In inhibit mode, or under an undefined code, update pulses still step the pointer, but no word is changed.
- R10: The pointer wraps from the last word (2^ADDR_W - 1) back to word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_clk | input | 1 | Asynchronous update clock from the programmer |
| mode | input | 4 | Asynchronous mode code; bit 0 is the first mode pin |
| dq_in | input | 8 | Byte received from the data pads |
| dq_out | output | 8 | Byte to drive onto the data pads |
| dq_oe | output | 1 | Pad output enable; high only in verify mode |

## Verification
The assertions assume that the mode code and the data byte change only while the update clock is low and has been stable for some time. They also assume that every update-clock level lasts at least three system cycles, so that the synchronizer sees each edge exactly once. The stimulus meets these assumptions in three ways:
- It holds each update-clock level for four system cycles.
- It changes the mode code and the data byte only between pulses.
- It waits six cycles after each mode change before pulsing again.

Under these conditions the pointer, the phase and the write commits follow the group structure without any skipped or doubled edges.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [1:0] {
    OP_INHIBIT = 2'd0,
    OP_CLEAR   = 2'd1,
    OP_WRITE   = 2'd2,
    OP_VERIFY  = 2'd3
  } otp_op_e;

  localparam logic [3:0] CODE_CLEAR  = 4'b0101;
  localparam logic [3:0] CODE_WRITE  = 4'b1110;
  localparam logic [3:0] CODE_VERIFY = 4'b1100;

  // phase on whose falling edge the pointer steps (third edge of a group)
  localparam logic [1:0] STEP_PHASE = 2'd2;

endpackage

// File: rtl/otp_sync.sv
module otp_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_pkg::*;
(
  input  logic [3:0] code,
  output otp_op_e    op
);

  always_comb begin
    unique case (code)
      CODE_CLEAR:       op = OP_CLEAR;
      CODE_WRITE:       op = OP_WRITE;
      CODE_VERIFY:      op = OP_VERIFY;
      default:          op = OP_INHIBIT;  // includes 4'b11x1 and all undefined codes
    endcase
  end

endmodule

// File: rtl/otp_addr_seq.sv
module otp_addr_seq
  import otp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uclk_s,
  input  logic              clr,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        phase,
  output logic              rise,
  output logic              fall,
  output logic              step
);

  logic uclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uclk_q <= 1'b0;
    else        uclk_q <= uclk_s;
  end

  assign rise = uclk_s & ~uclk_q;
  assign fall = ~uclk_s & uclk_q;
  assign step = fall & ~clr & (phase == STEP_PHASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      phase <= 2'd0;
    end else if (clr) begin
      addr  <= '0;
      phase <= 2'd0;
    end else if (fall) begin
      phase <= phase + 2'd1;
      if (step) addr <= addr + 1'b1;
    end
  end

  // R3
  phase_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !clr) |=> (phase == 2'($past(phase) + 2'd1)));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(addr));

  // R10
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (addr == ADDR_W'($past(addr) + 1'b1)));

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (addr == '0 && phase == 2'd0));

endmodule

// File: rtl/otp_array.sv
module otp_array #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (we) begin
      mem[addr] <= mem[addr] & wdata;
    end
  end

  assign rdata = mem[addr];

  // R7
  otp_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((mem[$past(addr)] & ~$past(rdata)) == '0));

endmodule

// File: rtl/otp_prog_port.sv
module otp_prog_port
  import otp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_clk,
  input  logic [3:0]          mode,
  input  logic [WORD_W/2-1:0] dq_in,
  output logic [WORD_W/2-1:0] dq_out,
  output logic                dq_oe
);

  localparam int BYTE_W = WORD_W / 2;
  localparam int SYNC_W = 1 + 4 + BYTE_W;

  logic [SYNC_W-1:0] sync_q;
  logic              uclk_s;
  logic [3:0]        mode_s;
  logic [BYTE_W-1:0] dq_s;
  otp_op_e           op;
  logic [ADDR_W-1:0] addr;
  logic [1:0]        phase;
  logic              rise, fall, step;
  logic              we;
  logic [WORD_W-1:0] rdata;
  logic [BYTE_W-1:0] lo_q;
  logic [BYTE_W-1:0] hi_hold;

  otp_sync #(.W(SYNC_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({upd_clk, mode, dq_in}),
    .q     (sync_q)
  );

  assign {uclk_s, mode_s, dq_s} = sync_q;

  otp_mode_dec u_dec (
    .code (mode_s),
    .op   (op)
  );

  otp_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .uclk_s (uclk_s),
    .clr    (op == OP_CLEAR),
    .addr   (addr),
    .phase  (phase),
    .rise   (rise),
    .fall   (fall),
    .step   (step)
  );

  assign we = step && (op == OP_WRITE);

  otp_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .addr  (addr),
    .wdata ({dq_s, lo_q}),
    .rdata (rdata)
  );

  // low byte captured in phases 0/1; high byte held across the pointer step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '1;
      hi_hold <= '1;
    end else begin
      if (rise && !phase[1] && op == OP_WRITE) lo_q <= dq_s;
      if (step) hi_hold <= rdata[WORD_W-1:BYTE_W];
    end
  end

  always_comb begin
    unique case (phase)
      2'd3:    dq_out = hi_hold;
      2'd2:    dq_out = rdata[WORD_W-1:BYTE_W];
      default: dq_out = rdata[BYTE_W-1:0];
    endcase
  end

  assign dq_oe = (op == OP_VERIFY);

  // R8
  oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we);

  // R5
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == OP_VERIFY) |=> (dq_out == $past(rdata[WORD_W-1:BYTE_W])));

  // R6
  commit_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (fall && phase == STEP_PHASE && !dq_oe));

endmodule

// File: tb/test_otp_prog_port.sv
module test_otp_prog_port;

  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_clk = 1'b0;
  logic [3:0] mode = 4'b1111;
  logic [7:0] dq_in = 8'h00;
  logic [7:0] dq_out;
  logic       dq_oe;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_mem [DEPTH];

  always #2 clk = ~clk;

  otp_prog_port #(.ADDR_W(AW), .WORD_W(16)) i_otp_prog_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_clk (upd_clk),
    .mode    (mode),
    .dq_in   (dq_in),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe)
  );

  function automatic logic [15:0] pat(int a);
    return 16'(a * 40503 + 4660) ^ 16'(a << 9);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_mode(logic [3:0] m);
    @(negedge clk);
    mode = m;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk);
    upd_clk = 1'b1;
    repeat (4) @(negedge clk);
    upd_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_group(logic [15:0] w);
    dq_in = w[7:0];
    pulse();
    pulse();
    dq_in = w[15:8];
    pulse();
    pulse();
  endtask

  // reads one group in verify mode and checks all four phases (R5, R3)
  task automatic read_group(int a);
    logic [15:0] e;
    e = exp_mem[a % DEPTH];
    check("R5 lo phase0", {8'h00, dq_out}, {8'h00, e[7:0]});
    pulse();
    check("R5 lo phase1", {8'h00, dq_out}, {8'h00, e[7:0]});
    pulse();
    check("R3 hi phase2", {8'h00, dq_out}, {8'h00, e[15:8]});
    pulse();
    check("R3 hi phase3", {8'h00, dq_out}, {8'h00, e[15:8]});
    pulse();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 oe after reset", {15'd0, dq_oe}, 16'd0);
    set_mode(4'b1100);
    check("R5 oe in verify", {15'd0, dq_oe}, 16'd1);
    check("R1 erased word 0 lo", {8'h00, dq_out}, 16'h00FF);

    // R8 output enable off in other modes
    set_mode(4'b0101);
    check("R8 oe in clear", {15'd0, dq_oe}, 16'd0);
    set_mode(4'b1101);
    check("R8 oe in inhibit", {15'd0, dq_oe}, 16'd0);
    set_mode(4'b0011);
    check("R8 oe undefined code", {15'd0, dq_oe}, 16'd0);
    set_mode(4'b0101);
    set_mode(4'b1110);
    check("R8 oe in write", {15'd0, dq_oe}, 16'd0);

    // R6 write sweep; some groups under inhibit or undefined codes (R2, R9)
    for (int a = 0; a < DEPTH; a++) begin
      if (a % 5 == 3) begin
        set_mode((a % 2 == 1) ? 4'b1111 : 4'b0010);
        write_group(pat(a));
        set_mode(4'b1110);
      end else begin
        write_group(pat(a));
        exp_mem[a] = exp_mem[a] & pat(a);
      end
    end

    // R10 pointer wrapped to 0: group 0 written again now lands on word 0
    write_group(16'hFFFF);

    // verify sweep with one extra group to see the wrap (R10)
    set_mode(4'b0101);
    set_mode(4'b1100);
    for (int a = 0; a <= DEPTH; a++) read_group(a);

    // R7 rewrite: zeros stay zero, new zeros are added
    set_mode(4'b0101);
    set_mode(4'b1110);
    for (int a = 0; a < 4; a++) begin
      write_group(~pat(a) ^ 16'h0F0F);
      exp_mem[a] = exp_mem[a] & (~pat(a) ^ 16'h0F0F);
    end
    set_mode(4'b0101);
    set_mode(4'b1100);
    for (int a = 0; a < 4; a++) read_group(a);

    // R4 clear resets the phase mid-group
    set_mode(4'b0101);
    set_mode(4'b1100);
    pulse();
    pulse();
    pulse();
    set_mode(4'b0101);
    set_mode(4'b1100);
    check("R4 phase cleared lo", {8'h00, dq_out}, {8'h00, exp_mem[0][7:0]});
    pulse();
    pulse();
    check("R4 phase cleared hi", {8'h00, dq_out}, {8'h00, exp_mem[0][15:8]});

    // R4 pulses during clear are ignored
    set_mode(4'b0101);
    pulse();
    pulse();
    pulse();
    pulse();
    set_mode(4'b1100);
    check("R4 pulses in clear ignored", {8'h00, dq_out}, {8'h00, exp_mem[0][7:0]});

    // R9 inhibit still steps the pointer
    set_mode(4'b1101);
    for (int k = 0; k < 4; k++) pulse();
    set_mode(4'b1100);
    check("R9 inhibit steps pointer", {8'h00, dq_out}, {8'h00, exp_mem[1][7:0]});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule